// File: doc/BRIEF.md
# SPI Channel Interrupt Status Aggregator

This block collects per-channel transfer events from up to four serial channels into one sticky interrupt status word. It gates that word with an enable mask and drives one level-sensitive interrupt line. Software reads the status, then clears bits by writing ones to them. Each channel supplies a receive-full pulse and a transmit-empty pulse. Each channel also supplies its transfer mode and turbo setting, and the block uses these to decide whether a pulse counts as an interrupt event.

A built-in self-test path lets software raise every implemented status bit without any serial traffic. This is for checking interrupt wiring and handlers. The path is active while a test-mode bit in the mode register and a set-all bit in the test register are both on. While it is active, software clears have no effect. A soft-reset bit in the configuration register returns all module registers to their reset values.

The register interface uses simple strobes. A write takes effect in the clock edge that samples `wr_en`. Read data appears on `rdata` one cycle after `rd_en` and holds until the next read. The word addresses are: 0 identity, 1 configuration, 2 reset-done, 3 status, 4 enable, 5 wake enable, 6 test, 7 mode.

Top module: `spi_irq_agg`

## Requirements
- R1: For channel n, a qualified transmit-empty pulse sets status bit 4n and a qualified receive-full pulse sets status bit 4n+2. Set bits stay set until cleared.
- R2: A channel's mode field is 2 bits wide. Mode 2'b01 means receive-only, so transmit-empty pulses are dropped. Mode 2'b10 means transmit-only, so receive-full pulses are dropped. A receive-full pulse is also dropped while the channel's turbo input is 1.
- R3: A write to address 3 clears each status bit that is 1 in `wdata`. If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R4: The enable register (address 4) keeps only the bits in mask 0x1777F. `irq_o` is high when status AND enable is nonzero, and it follows that condition with one cycle of delay.
- R5: A write to address 3 changes nothing while mode bit 3 and test bit 11 are both 1.
- R6: All status bits in mask 0x1777F become 1 in two cases. The first is a write to address 6 with `wdata` bit 11 set while mode bit 3 is 1. The second is a write to address 7 with `wdata` bit 3 set while test bit 11 is already 1.
- R7: A write to address 1 with `wdata` bit 1 set is a soft reset. It clears status, enable, wake enable and test, and sets mode to 4. It stores `wdata` & 0x31D in the configuration register. It takes priority over events in the same cycle.
- R8: The mode register keeps `wdata`[3:0], the test register keeps `wdata`[11:0], and the wake-enable register keeps `wdata`[0]. A write to address 1 without bit 1 set stores `wdata` & 0x31D.
- R9: Address 0 always reads the parameter `REV_ID`. Address 2 always reads 1. Writes to these two addresses have no effect.
- R10: After reset, mode reads 4, every other writable register and status read 0, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is valid the following cycle |
| addr | input | 3 | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ch_rx_full | input | NUM_CH | Receive-full event pulses, one bit per channel |
| ch_tx_empty | input | NUM_CH | Transmit-empty event pulses, one bit per channel |
| ch_mode | input | 2*NUM_CH | Transfer mode per channel; bits [2n+1:2n] belong to channel n |
| ch_turbo | input | NUM_CH | Turbo setting per channel |
| irq_o | output | 1 | Registered interrupt line |

## Verification
The hardest case to reach from the ports is the one where clearing is locked out. Both the test-mode bit and the set-all bit must be on, and the two can be armed in either order. Each order triggers the force through a different register. The stimulus first arms set-all with test mode off, and checks that nothing is forced. It then turns on test mode to force the status word and shows that a full clear write leaves it unchanged. Next it disarms, clears, and re-arms in the opposite order. The same-cycle collisions are driven by raising an event pulse in the very cycle of a clear write or a soft reset. These are the event-versus-clear collision and the event-versus-soft-reset collision.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

   typedef enum logic [2:0] {
      A_ID   = 3'd0,
      A_CFG  = 3'd1,
      A_DONE = 3'd2,
      A_STAT = 3'd3,
      A_ENA  = 3'd4,
      A_WAKE = 3'd5,
      A_TEST = 3'd6,
      A_MODE = 3'd7
   } reg_addr_e;

   localparam logic [1:0] MODE_RX_ONLY = 2'b01;
   localparam logic [1:0] MODE_TX_ONLY = 2'b10;

   localparam int CFG_SRST_BIT  = 1;
   localparam int MODE_TEST_BIT = 3;
   localparam int TEST_SET_BIT  = 11;
   localparam int EVT_STRIDE    = 4;
   localparam int EVT_TX_OFS    = 0;
   localparam int EVT_RX_OFS    = 2;

endpackage

// File: rtl/spi_irq_evt_qual.sv
module spi_irq_evt_qual
   import spi_irq_pkg::*;
#(
   parameter bit HAS_TURBO = 1'b1
) (
   input  logic       rx_flag,
   input  logic       tx_flag,
   input  logic [1:0] mode,
   input  logic       turbo,
   output logic       rx_evt,
   output logic       tx_evt
);

   assign tx_evt = tx_flag && (mode != MODE_RX_ONLY);

   generate
      if (HAS_TURBO) begin : g_turbo
         assign rx_evt = rx_flag && (mode != MODE_TX_ONLY) && !turbo;
      end else begin : g_plain
         logic unused_turbo;
         assign unused_turbo = turbo;
         assign rx_evt = rx_flag && (mode != MODE_TX_ONLY);
      end
   endgenerate

endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
   import spi_irq_pkg::*;
#(
   parameter int          DW        = 32,
   parameter int          MODE_W    = 4,
   parameter int          TEST_W    = 12,
   parameter logic [31:0] ENA_MASK  = 32'h0001_777F,
   parameter logic [31:0] CFG_KEEP  = 32'h0000_031D,
   parameter int          MODE_RST  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     cfg_q,
   output logic [DW-1:0]     ena_q,
   output logic              wake_q,
   output logic [TEST_W-1:0] test_q,
   output logic [MODE_W-1:0] mode_q,
   output logic              soft_rst,
   output logic              force_set,
   output logic              clr_we,
   output logic              clr_block
);

   localparam logic [DW-1:0] ENA_KEEP = DW'(ENA_MASK);
   localparam logic [DW-1:0] CFG_MSK  = DW'(CFG_KEEP);
   localparam logic [MODE_W-1:0] MODE_INIT = MODE_W'(MODE_RST);

   if (MODE_W <= MODE_TEST_BIT) begin : g_bad_mode
      $error("spi_irq_ctrl: MODE_W too small for the test-mode bit");
   end
   if (TEST_W <= TEST_SET_BIT) begin : g_bad_test
      $error("spi_irq_ctrl: TEST_W too small for the set-all bit");
   end

   logic we_cfg, we_ena, we_wake, we_test, we_mode;

   assign we_cfg  = wr_en && (addr == A_CFG);
   assign we_ena  = wr_en && (addr == A_ENA);
   assign we_wake = wr_en && (addr == A_WAKE);
   assign we_test = wr_en && (addr == A_TEST);
   assign we_mode = wr_en && (addr == A_MODE);
   assign clr_we  = wr_en && (addr == A_STAT);

   assign soft_rst  = we_cfg && wdata[CFG_SRST_BIT];
   assign clr_block = mode_q[MODE_TEST_BIT] && test_q[TEST_SET_BIT];
   assign force_set = (we_test && wdata[TEST_SET_BIT] && mode_q[MODE_TEST_BIT]) ||
                      (we_mode && wdata[MODE_TEST_BIT] && test_q[TEST_SET_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         ena_q  <= '0;
         wake_q <= 1'b0;
         test_q <= '0;
         mode_q <= MODE_INIT;
      end else if (soft_rst) begin
         cfg_q  <= wdata & CFG_MSK;
         ena_q  <= '0;
         wake_q <= 1'b0;
         test_q <= '0;
         mode_q <= MODE_INIT;
      end else begin
         if (we_cfg)  cfg_q  <= wdata & CFG_MSK;
         if (we_ena)  ena_q  <= wdata & ENA_KEEP;
         if (we_wake) wake_q <= wdata[0];
         if (we_test) test_q <= wdata[TEST_W-1:0];
         if (we_mode) mode_q <= wdata[MODE_W-1:0];
      end
   end

   // R7
   soft_rst_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (mode_q == MODE_INIT) && (ena_q == '0) && (test_q == '0) && !wake_q);

   // R4
   ena_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we_ena && !soft_rst |=> ((ena_q & ~ENA_KEEP) == '0));

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
   parameter int          DW        = 32,
   parameter logic [31:0] IMPL_MASK = 32'h0001_777F
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] evt_set,
   input  logic          clr_we,
   input  logic          clr_block,
   input  logic [DW-1:0] clr_val,
   input  logic          force_set,
   input  logic          soft_rst,
   output logic [DW-1:0] status_q
);

   localparam logic [DW-1:0] KEEP = DW'(IMPL_MASK);

   logic [DW-1:0] st_nxt;

   always_comb begin
      st_nxt = status_q;
      if (clr_we && !clr_block) st_nxt = st_nxt & ~clr_val;
      if (force_set)            st_nxt = st_nxt | KEEP;
      st_nxt = (st_nxt | evt_set) & KEEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        status_q <= '0;
      else if (soft_rst) status_q <= '0;
      else               status_q <= st_nxt;
   end

   // R5
   clr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_block && !soft_rst) |=> ((status_q & $past(status_q)) == $past(status_q)));

   // R6
   force_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (force_set && !soft_rst) |=> ((status_q & KEEP) == KEEP));

   // R3
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!soft_rst && (evt_set != '0)) |=> ((status_q & $past(evt_set)) == $past(evt_set)));

   // R7
   soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (status_q == '0));

endmodule

// File: rtl/spi_irq_agg.sv
module spi_irq_agg
   import spi_irq_pkg::*;
#(
   parameter int          NUM_CH    = 4,
   parameter int          DW        = 32,
   parameter logic [31:0] REV_ID    = 32'h0000_0130,
   parameter logic [31:0] IMPL_MASK = 32'h0001_777F,
   parameter logic [31:0] CFG_KEEP  = 32'h0000_031D,
   parameter bit          HAS_TURBO = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [2:0]          addr,
   input  logic [DW-1:0]       wdata,
   output logic [DW-1:0]       rdata,
   input  logic [NUM_CH-1:0]   ch_rx_full,
   input  logic [NUM_CH-1:0]   ch_tx_empty,
   input  logic [2*NUM_CH-1:0] ch_mode,
   input  logic [NUM_CH-1:0]   ch_turbo,
   output logic                irq_o
);

   localparam int MODE_W = 4;
   localparam int TEST_W = 12;
   localparam int TOP_BIT = EVT_STRIDE * (NUM_CH - 1) + EVT_RX_OFS;

   if (NUM_CH < 1 || NUM_CH > 4) begin : g_bad_ch
      $error("spi_irq_agg: NUM_CH must be 1 to 4");
   end
   if (DW <= TOP_BIT || DW < 17 || DW < TEST_W) begin : g_bad_dw
      $error("spi_irq_agg: DW too narrow for the status layout");
   end

   logic [NUM_CH-1:0] rx_evt, tx_evt;
   logic [DW-1:0]     evt_vec;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      spi_irq_evt_qual #(.HAS_TURBO(HAS_TURBO)) u_qual (
         .rx_flag (ch_rx_full[n]),
         .tx_flag (ch_tx_empty[n]),
         .mode    (ch_mode[2*n +: 2]),
         .turbo   (ch_turbo[n]),
         .rx_evt  (rx_evt[n]),
         .tx_evt  (tx_evt[n])
      );
   end

   always_comb begin
      evt_vec = '0;
      for (int n = 0; n < NUM_CH; n++) begin
         evt_vec[EVT_STRIDE*n + EVT_TX_OFS] = tx_evt[n];
         evt_vec[EVT_STRIDE*n + EVT_RX_OFS] = rx_evt[n];
      end
   end

   logic [DW-1:0]     cfg_q, ena_q, status_q;
   logic              wake_q;
   logic [TEST_W-1:0] test_q;
   logic [MODE_W-1:0] mode_q;
   logic              soft_rst, force_set, clr_we, clr_block;

   spi_irq_ctrl #(
      .DW       (DW),
      .MODE_W   (MODE_W),
      .TEST_W   (TEST_W),
      .ENA_MASK (IMPL_MASK),
      .CFG_KEEP (CFG_KEEP),
      .MODE_RST (4)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .addr      (addr),
      .wdata     (wdata),
      .cfg_q     (cfg_q),
      .ena_q     (ena_q),
      .wake_q    (wake_q),
      .test_q    (test_q),
      .mode_q    (mode_q),
      .soft_rst  (soft_rst),
      .force_set (force_set),
      .clr_we    (clr_we),
      .clr_block (clr_block)
   );

   spi_irq_status #(
      .DW        (DW),
      .IMPL_MASK (IMPL_MASK)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_set   (evt_vec),
      .clr_we    (clr_we),
      .clr_block (clr_block),
      .clr_val   (wdata),
      .force_set (force_set),
      .soft_rst  (soft_rst),
      .status_q  (status_q)
   );

   logic [DW-1:0] rd_mux;

   always_comb begin
      unique case (reg_addr_e'(addr))
         A_ID:    rd_mux = DW'(REV_ID);
         A_CFG:   rd_mux = cfg_q;
         A_DONE:  rd_mux = DW'(1);
         A_STAT:  rd_mux = status_q;
         A_ENA:   rd_mux = ena_q;
         A_WAKE:  rd_mux = {{(DW-1){1'b0}}, wake_q};
         A_TEST:  rd_mux = {{(DW-TEST_W){1'b0}}, test_q};
         A_MODE:  rd_mux = {{(DW-MODE_W){1'b0}}, mode_q};
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         irq_o <= 1'b0;
      end else begin
         if (rd_en) rdata <= rd_mux;
         irq_o <= |(status_q & ena_q);
      end
   end

   // R4
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past((status_q & ena_q) != '0));

   // R4
   irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past((status_q & ena_q) == '0));

endmodule

// File: tb/spi_irq_agg_tb.sv
`timescale 1ns/1ps
module spi_irq_agg_tb;

   localparam int NUM_CH = 4;
   localparam logic [31:0] REV = 32'h0000_0130;
   localparam logic [31:0] M   = 32'h0001_777F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [2:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NUM_CH-1:0] ch_rx_full = '0, ch_tx_empty = '0, ch_turbo = '0;
   logic [2*NUM_CH-1:0] ch_mode = '0;
   logic irq_o;

   always #4 clk = ~clk;

   spi_irq_agg u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .ch_rx_full(ch_rx_full),
      .ch_tx_empty(ch_tx_empty), .ch_mode(ch_mode), .ch_turbo(ch_turbo),
      .irq_o(irq_o)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   typedef struct {
      string       req;
      logic [2:0]  a;
      logic [31:0] exp;
   } item_t;
   item_t exp_q[$];

   logic rd_seen = 1'b0;
   always @(posedge clk) rd_seen <= rd_en;

   // monitor: compares read data against the scoreboard queue
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         item_t it;
         it = exp_q.pop_front();
         n_chk++;
         if (rdata !== it.exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", it.req, it.a, rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
      item_t it;
      it.req = req; it.a = a; it.exp = e;
      exp_q.push_back(it);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(input logic [NUM_CH-1:0] rx, input logic [NUM_CH-1:0] tx);
      ch_rx_full = rx; ch_tx_empty = tx;
      @(negedge clk);
      ch_rx_full = '0; ch_tx_empty = '0;
   endtask

   task automatic chk_irq(input logic e, input string req);
      n_chk++;
      if (irq_o !== e) begin
         n_bad++;
         $display("FAIL %s irq actual=%b expected=%b", req, irq_o, e);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL R10 watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset values, R9 constants
      chk_irq(1'b0, "R10");
      rd(3'd7, 32'h4, "R10 mode");
      rd(3'd3, 32'h0, "R10 status");
      rd(3'd4, 32'h0, "R10 enable");
      rd(3'd6, 32'h0, "R10 test");
      rd(3'd5, 32'h0, "R10 wake");
      rd(3'd1, 32'h0, "R10 cfg");
      rd(3'd0, REV, "R9 id");
      rd(3'd2, 32'h1, "R9 done");

      // R1 transmit-empty positions
      pulse(4'h0, 4'hF);
      rd(3'd3, 32'h0000_1111, "R1 tx bits");
      wr(3'd3, 32'h0000_1111);
      rd(3'd3, 32'h0, "R3 clear");
      // R1 receive-full positions
      pulse(4'hF, 4'h0);
      rd(3'd3, 32'h0000_4444, "R1 rx bits");
      wr(3'd3, 32'hFFFF_FFFF);

      // R2 qualification: ch0 tx-only, ch1 rx-only, ch2 turbo
      ch_mode = 8'b00_00_01_10;
      ch_turbo = 4'b0100;
      pulse(4'b0111, 4'b0111);
      rd(3'd3, 32'h0000_0141, "R2 qualify");
      ch_mode = '0; ch_turbo = '0;

      // R4 enable mask and registered interrupt
      chk_irq(1'b0, "R4 masked");
      wr(3'd4, 32'hFFFF_FFFF);
      chk_irq(1'b0, "R4 delay");
      @(negedge clk);
      chk_irq(1'b1, "R4 asserted");
      rd(3'd4, M, "R4 enable mask");
      wr(3'd3, 32'h0000_0141);
      chk_irq(1'b1, "R4 delay on clear");
      @(negedge clk);
      chk_irq(1'b0, "R4 deasserted");

      // R3 set wins over clear in the same cycle
      ch_tx_empty = 4'b0001;
      wr_en = 1'b1; addr = 3'd3; wdata = 32'h1;
      @(negedge clk);
      wr_en = 1'b0; ch_tx_empty = '0;
      rd(3'd3, 32'h1, "R3 set wins");

      // R6 arm set-all first, test mode off: no force
      wr(3'd6, 32'h0000_0800);
      rd(3'd3, 32'h1, "R6 no force without test mode");
      wr(3'd7, 32'h0000_000C);
      rd(3'd3, M, "R6 force via mode");
      rd(3'd7, 32'hC, "R8 mode");
      // R5 clear blocked
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd3, M, "R5 clear blocked");

      // unlock, clear, re-arm through the test register
      wr(3'd6, 32'h0);
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd3, 32'h0, "R5 clear after unlock");
      wr(3'd6, 32'h0000_0800);
      rd(3'd3, M, "R6 force via test");

      // R8 widths
      wr(3'd6, 32'hFFFF_FFFF);
      rd(3'd6, 32'h0000_0FFF, "R8 test width");
      wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd7, 32'hF, "R8 mode width");
      wr(3'd5, 32'hFFFF_FFFF);
      rd(3'd5, 32'h1, "R8 wake width");
      chk_irq(1'b1, "R4 forced");

      // R7 soft reset with a same-cycle event
      ch_tx_empty = 4'b0001;
      wr_en = 1'b1; addr = 3'd1; wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      wr_en = 1'b0; ch_tx_empty = '0;
      rd(3'd3, 32'h0, "R7 status");
      chk_irq(1'b0, "R7 irq");
      rd(3'd4, 32'h0, "R7 enable");
      rd(3'd5, 32'h0, "R7 wake");
      rd(3'd6, 32'h0, "R7 test");
      rd(3'd7, 32'h4, "R7 mode");
      rd(3'd1, 32'h0000_031D, "R7 cfg");
      wr(3'd1, 32'h0000_00F5);
      rd(3'd1, 32'h0000_0015, "R8 cfg keep");
      rd(3'd7, 32'h4, "R8 mode kept");

      // R9 constant registers ignore writes
      wr(3'd0, 32'hFFFF_FFFF);
      wr(3'd2, 32'h0);
      rd(3'd0, REV, "R9 id after write");
      rd(3'd2, 32'h1, "R9 done after write");

      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule